// File: doc/BRIEF.md
# Qualified Event Counter

This block is one programmable performance-monitoring counter. Every cycle it receives a bundle of small per-cycle event counts (one 3-bit lane per event source), the current privilege ring and a halt indication. A configuration register picks one lane through an event code and a unit mask, then sets how that lane's value is qualified before it reaches a 40-bit accumulator. The qualifiers are a threshold compare that can be inverted, a rising-edge mode, and privilege filtering.

With no threshold the counter adds the raw per-cycle count. With a threshold it adds at most one per cycle. In edge mode it adds one only when the qualified condition goes from false to true. Software loads the accumulator directly and reads it continuously. A carry out of the top bit can latch a sticky overflow flag and pulse an interrupt.

Two small state machines carry the block's history. The edge tracker has states COND_LOW and COND_HIGH, with transitions *rise* (condition true while in COND_LOW) and *fall* (condition false while in COND_HIGH). The overflow tracker has states OVF_CLEAR and OVF_SET, with transitions *wrap* (a carry out while interrupts are enabled and no software write is present) and *reload* (a software write to the counter).

Top module: `pmc_event_ctr`

## Requirements
- R1: The configuration word `cfg_wdata` is latched on `cfg_wr` and applies from the following cycle. Its fields are: bits [7:0] event code, [15:8] unit mask, [18:16] threshold, bit 19 invert, bit 20 edge mode, bit 21 ring-0 enable, bit 22 ring-1..3 enable, bit 23 interrupt enable. Event code 0x80+i with unit mask 0x00 selects lane i, which is `evt_cnt[3i+2:3i]`. Lane 6 is accepted only on counter instance 0 and lane 7 only on instance 1. Any other code or mask selects a count of zero.
- R2: With threshold 0 and edge mode off, the counter adds the full selected lane value (0 to 7) each cycle.
- R3: With a nonzero threshold and invert off, the counter adds one in a cycle whose selected value is greater than or equal to the threshold, and zero otherwise.
- R4: With a nonzero threshold and invert on, the counter adds one when the selected value is below the threshold. With threshold 0, invert has no effect.
- R5: With edge mode on, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. The qualified condition is the threshold pass, or a nonzero value when the threshold is 0, gated by R6 and R7.
- R6: If only the ring-0 enable is set, counting happens only when `priv` is 0. If only the ring-1..3 enable is set, counting happens only when `priv` is 1, 2 or 3. If both or neither are set, counting happens at every ring.
- R7: While `halted` is high, nothing is counted and the qualified condition is false.
- R8: `ctr_wr` loads `ctr_wdata` into the counter on the next edge, overrides any increment in that cycle, and clears the overflow flag.
- R9: When an increment carries out of bit 39 with the interrupt enable set, the counter wraps, `ovf_flag` goes high and stays high until the next `ctr_wr`, and `irq` is high for exactly that one cycle. Without the interrupt enable, a wrap sets neither output.
- R10: After reset the count, `ovf_flag`, `irq` and the configuration are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_cnt | input | 24 | Eight 3-bit per-cycle event counts, lane i at bits [3i+2:3i] |
| priv | input | 2 | Current privilege ring, 0 to 3 |
| halted | input | 1 | Core halted, suppresses counting |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration word, field layout in R1 |
| ctr_wr | input | 1 | Counter write strobe |
| ctr_wdata | input | 40 | Counter load value |
| ctr_rdata | output | 40 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The hardest situation to reach is the carry out of a 40-bit accumulator. Natural counting would need about 2^40 events, so the stimulus preloads the counter through `ctr_wr` with values a few counts below all-ones. It then applies lane values that cross the boundary, both with and without the interrupt enable. The random phase also picks its load values close to the top, so wraps happen alongside random qualifier settings, privilege rings, halts, and writes that collide with increments. Edge mode is reached by directed lane sequences that hold the condition high for several cycles before dropping and raising it again.

// File: rtl/pmc_ctr_pkg.sv
package pmc_ctr_pkg;

    localparam int LANE_W = 3;

    typedef struct packed {
        logic              irq_en;
        logic              usr_en;
        logic              os_en;
        logic              edge_en;
        logic              inv;
        logic [LANE_W-1:0] thresh;
        logic [7:0]        umask;
        logic [7:0]        code;
    } ctr_cfg_t;

    localparam int CFG_W = $bits(ctr_cfg_t);

    typedef enum logic {
        COND_LOW,
        COND_HIGH
    } cond_st_e;

    typedef enum logic {
        OVF_CLEAR,
        OVF_SET
    } ovf_st_e;

endpackage

// File: rtl/pmc_evsel.sv
module pmc_evsel #(
    parameter int          NUM_LANES = 8,
    parameter int          LANE_W    = 3,
    parameter int          CTR_ID    = 0,
    parameter logic [7:0]  BASE_CODE = 8'h80
) (
    input  logic [NUM_LANES*LANE_W-1:0] evt_cnt,
    input  logic [7:0]                  code,
    input  logic [7:0]                  umask,
    output logic [LANE_W-1:0]           sel_cnt,
    output logic                        sel_ok
);
    localparam int IDX_W = $clog2(NUM_LANES);

    logic [LANE_W-1:0] lane_arr [NUM_LANES];
    logic [NUM_LANES-1:0] lane_ok;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam bit ONLY_CTR0 = (i == NUM_LANES - 2);
        localparam bit ONLY_CTR1 = (i == NUM_LANES - 1);
        assign lane_arr[i] = evt_cnt[i*LANE_W +: LANE_W];
        if (ONLY_CTR0) begin : g_c0
            assign lane_ok[i] = (CTR_ID == 0);
        end else if (ONLY_CTR1) begin : g_c1
            assign lane_ok[i] = (CTR_ID == 1);
        end else begin : g_any
            assign lane_ok[i] = 1'b1;
        end
    end

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = code[IDX_W-1:0];
        sel_ok  = (code[7:IDX_W] == BASE_CODE[7:IDX_W]) && (umask == 8'h00)
                  && lane_ok[idx];
        sel_cnt = sel_ok ? lane_arr[idx] : '0;
    end

endmodule

// File: rtl/pmc_qualify.sv
module pmc_qualify
    import pmc_ctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] sel_cnt,
    input  ctr_cfg_t          cfg,
    input  logic [1:0]        priv,
    input  logic              halted,
    output logic [LANE_W-1:0] inc
);
    cond_st_e state_q, state_d;
    logic     ring_ok, gate, pass, cond;

    always_comb begin
        ring_ok = (!cfg.os_en && !cfg.usr_en)
                  || (cfg.os_en && (priv == 2'd0))
                  || (cfg.usr_en && (priv != 2'd0));
        gate    = ring_ok && !halted;
        if (cfg.thresh == '0)
            pass = (sel_cnt != '0);
        else if (cfg.inv)
            pass = (sel_cnt < cfg.thresh);
        else
            pass = (sel_cnt >= cfg.thresh);
        cond    = gate && pass;
    end

    // edge tracker state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= COND_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            COND_LOW:  if (cond)  state_d = COND_HIGH;  // rise
            COND_HIGH: if (!cond) state_d = COND_LOW;   // fall
            default:   state_d = COND_LOW;
        endcase
    end

    // output process
    always_comb begin
        if (cfg.edge_en)
            inc = (state_q == COND_LOW && cond) ? LANE_W'(1) : '0;
        else if (cfg.thresh != '0)
            inc = cond ? LANE_W'(1) : '0;
        else
            inc = gate ? sel_cnt : '0;
    end

    // R3
    thresh_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.thresh != '0) |-> (inc <= LANE_W'(1)));

    // R5
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.edge_en && inc != '0) |=> (!cfg.edge_en || inc == '0));

    // R6
    ring0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.os_en && !cfg.usr_en && priv != 2'd0) |-> (inc == '0));

    // R7
    halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (inc == '0));

endmodule

// File: rtl/pmc_accum.sv
module pmc_accum
    import pmc_ctr_pkg::*;
#(
    parameter int CTR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] inc,
    input  logic              irq_en,
    input  logic              ctr_wr,
    input  logic [CTR_W-1:0]  ctr_wdata,
    output logic [CTR_W-1:0]  cnt,
    output logic              ovf_flag,
    output logic              irq
);
    ovf_st_e        state_q, state_d;
    logic [CTR_W:0] sum;
    logic           wrap;

    always_comb begin
        sum  = {1'b0, cnt} + (CTR_W+1)'(inc);
        wrap = sum[CTR_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            cnt <= ctr_wr ? ctr_wdata : sum[CTR_W-1:0];
            irq <= !ctr_wr && wrap && irq_en;
        end
    end

    // overflow tracker state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OVF_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_CLEAR: if (!ctr_wr && wrap && irq_en) state_d = OVF_SET;  // wrap
            OVF_SET:   if (ctr_wr)                    state_d = OVF_CLEAR; // reload
            default:   state_d = OVF_CLEAR;
        endcase
    end

    // output process
    always_comb begin
        ovf_flag = (state_q == OVF_SET);
    end

    // R8
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_wr |=> (cnt == $past(ctr_wdata) && !ovf_flag));

    // R9
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: rtl/pmc_event_ctr.sv
module pmc_event_ctr
    import pmc_ctr_pkg::*;
#(
    parameter int         NUM_LANES = 8,
    parameter int         CTR_W     = 40,
    parameter int         CTR_ID    = 0,
    parameter logic [7:0] BASE_CODE = 8'h80
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES*LANE_W-1:0] evt_cnt,
    input  logic [1:0]                  priv,
    input  logic                        halted,
    input  logic                        cfg_wr,
    input  logic [CFG_W-1:0]            cfg_wdata,
    input  logic                        ctr_wr,
    input  logic [CTR_W-1:0]            ctr_wdata,
    output logic [CTR_W-1:0]            ctr_rdata,
    output logic                        ovf_flag,
    output logic                        irq
);
    ctr_cfg_t          cfg_q;
    logic [LANE_W-1:0] sel_cnt;
    logic              sel_ok;
    logic [LANE_W-1:0] inc;

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= ctr_cfg_t'(cfg_wdata);
    end

    pmc_evsel #(
        .NUM_LANES (NUM_LANES),
        .LANE_W    (LANE_W),
        .CTR_ID    (CTR_ID),
        .BASE_CODE (BASE_CODE)
    ) u_evsel (
        .evt_cnt (evt_cnt),
        .code    (cfg_q.code),
        .umask   (cfg_q.umask),
        .sel_cnt (sel_cnt),
        .sel_ok  (sel_ok)
    );

    pmc_qualify u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_cnt (sel_cnt),
        .cfg     (cfg_q),
        .priv    (priv),
        .halted  (halted),
        .inc     (inc)
    );

    pmc_accum #(.CTR_W(CTR_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (inc),
        .irq_en    (cfg_q.irq_en),
        .ctr_wr    (ctr_wr),
        .ctr_wdata (ctr_wdata),
        .cnt       (ctr_rdata),
        .ovf_flag  (ovf_flag),
        .irq       (irq)
    );

    // R1
    bad_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.umask != 8'h00) |-> (sel_cnt == '0 && !sel_ok));

endmodule

// File: tb/sim_pmc_event_ctr.sv
`timescale 1ns/1ps
module sim_pmc_event_ctr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt_cnt = '0;
    logic [1:0]  priv = '0;
    logic        halted = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        ctr_wr = 1'b0;
    logic [39:0] ctr_wdata = '0;
    logic [39:0] ctr_rdata;
    logic        ovf_flag, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [23:0] m_cfg  = '0;
    logic [39:0] m_cnt  = '0;
    logic        m_flag = 1'b0;
    logic        m_irq  = 1'b0;
    logic        m_prev = 1'b0;

    localparam logic [39:0] TOP = {40{1'b1}};

    always #10 clk = ~clk;

    pmc_event_ctr u0 (
        .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .priv(priv),
        .halted(halted), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata), .ctr_rdata(ctr_rdata),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    function automatic logic [23:0] mk_cfg(input logic [7:0] code, input logic [7:0] um,
        input logic [2:0] thr, input logic inv, input logic edg, input logic os,
        input logic usr, input logic ie);
        return {ie, usr, os, edg, inv, thr, um, code};
    endfunction

    function automatic logic [2:0] m_sel(input logic [23:0] c, input logic [23:0] lanes);
        logic [2:0] i;
        i = c[2:0];
        if (c[7:3] == 5'b10000 && c[15:8] == 8'h00 && i != 3'd7)
            return lanes[i*3 +: 3];
        return 3'd0;
    endfunction

    function automatic string tag_of(input logic [23:0] c);
        if (c[20]) return "R5";
        if (c[18:16] != 0 && c[19]) return "R4";
        if (c[18:16] != 0) return "R3";
        return "R2";
    endfunction

    task automatic cycle(input string tag);
        logic [2:0]  s, thr, inc;
        logic        ring, gate, pass, cond;
        logic [40:0] sum;
        s    = m_sel(m_cfg, evt_cnt);
        thr  = m_cfg[18:16];
        ring = (!m_cfg[21] && !m_cfg[22]) || (m_cfg[21] && priv == 0)
               || (m_cfg[22] && priv != 0);
        gate = ring && !halted;
        pass = (thr == 0) ? (s != 0) : (m_cfg[19] ? (s < thr) : (s >= thr));
        cond = gate && pass;
        if (m_cfg[20])     inc = (cond && !m_prev) ? 3'd1 : 3'd0;
        else if (thr != 0) inc = cond ? 3'd1 : 3'd0;
        else               inc = gate ? s : 3'd0;
        m_prev = cond;
        if (ctr_wr) begin
            m_cnt = ctr_wdata; m_flag = 0; m_irq = 0;
        end else begin
            sum   = {1'b0, m_cnt} + 41'(inc);
            m_cnt = sum[39:0];
            m_irq = sum[40] && m_cfg[23];
            if (m_irq) m_flag = 1;
        end
        if (cfg_wr) m_cfg = cfg_wdata;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 0;
        ctr_wr = 0;
        total++;
        if (ctr_rdata !== m_cnt || ovf_flag !== m_flag || irq !== m_irq) begin
            bad++;
            $display("FAIL %s: cnt=%h flag=%b irq=%b expected cnt=%h flag=%b irq=%b",
                     tag, ctr_rdata, ovf_flag, irq, m_cnt, m_flag, m_irq);
        end
    endtask

    task automatic set_cfg(input logic [23:0] v, input string tag);
        cfg_wdata = v; cfg_wr = 1; evt_cnt = '0;
        cycle(tag);
    endtask

    task automatic load(input logic [39:0] v, input string tag);
        ctr_wdata = v; ctr_wr = 1;
        cycle(tag);
    endtask

    task automatic lane(input int i, input logic [2:0] v, input string tag);
        evt_cnt = '0;
        evt_cnt[i*3 +: 3] = v;
        cycle(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        cycle("R10 reset state");
        cycle("R10 idle");

        // R1 lane selection
        set_cfg(mk_cfg(8'h82, 8'h00, 0, 0, 0, 0, 0, 0), "R1");
        evt_cnt = 24'hFFFFFF; evt_cnt[6 +: 3] = 3'd5; cycle("R1 lane2");
        set_cfg(mk_cfg(8'h82, 8'h01, 0, 0, 0, 0, 0, 0), "R1");
        lane(2, 3'd6, "R1 bad umask");
        set_cfg(mk_cfg(8'h87, 8'h00, 0, 0, 0, 0, 0, 0), "R1");
        lane(7, 3'd7, "R1 lane7 on ctr0");
        set_cfg(mk_cfg(8'h86, 8'h00, 0, 0, 0, 0, 0, 0), "R1");
        lane(6, 3'd7, "R1 lane6 on ctr0");
        set_cfg(mk_cfg(8'h42, 8'h00, 0, 0, 0, 0, 0, 0), "R1");
        lane(2, 3'd3, "R1 bad code");

        // R2 raw counts, R4 invert without threshold
        set_cfg(mk_cfg(8'h83, 8'h00, 0, 1, 0, 0, 0, 0), "R2");
        lane(3, 3'd7, "R2 full add");
        lane(3, 3'd0, "R4 invert ignored at thr0");
        lane(3, 3'd2, "R2 add 2");

        // R3 threshold
        set_cfg(mk_cfg(8'h81, 8'h00, 3'd4, 0, 0, 0, 0, 0), "R3");
        lane(1, 3'd3, "R3 below");
        lane(1, 3'd4, "R3 equal");
        lane(1, 3'd7, "R3 above");
        // R4 inverted threshold
        set_cfg(mk_cfg(8'h81, 8'h00, 3'd4, 1, 0, 0, 0, 0), "R4");
        lane(1, 3'd3, "R4 below");
        lane(1, 3'd4, "R4 equal");
        lane(1, 3'd0, "R4 zero");

        // R5 edge mode
        set_cfg(mk_cfg(8'h81, 8'h00, 3'd2, 0, 1, 0, 0, 0), "R5");
        lane(1, 3'd3, "R5 rise");
        lane(1, 3'd3, "R5 hold");
        lane(1, 3'd5, "R5 hold");
        lane(1, 3'd0, "R5 drop");
        lane(1, 3'd4, "R5 rise again");

        // R6 privilege rings
        set_cfg(mk_cfg(8'h80, 8'h00, 0, 0, 0, 1, 0, 0), "R6");
        for (int p = 0; p < 4; p++) begin priv = 2'(p); lane(0, 3'd3, "R6 os only"); end
        set_cfg(mk_cfg(8'h80, 8'h00, 0, 0, 0, 0, 1, 0), "R6");
        for (int p = 0; p < 4; p++) begin priv = 2'(p); lane(0, 3'd3, "R6 usr only"); end
        set_cfg(mk_cfg(8'h80, 8'h00, 0, 0, 0, 1, 1, 0), "R6");
        for (int p = 0; p < 4; p++) begin priv = 2'(p); lane(0, 3'd1, "R6 both"); end
        priv = 0;

        // R7 halted
        halted = 1; lane(0, 3'd7, "R7 halted"); halted = 0;
        lane(0, 3'd2, "R7 resume");

        // R8 write beats increment
        evt_cnt = '0; evt_cnt[2:0] = 3'd7;
        load(40'h12_3456_789A, "R8 load wins");

        // R9 overflow with interrupt enabled
        set_cfg(mk_cfg(8'h80, 8'h00, 0, 0, 0, 0, 0, 1), "R9");
        load(TOP - 40'd2, "R9 preload");
        lane(0, 3'd5, "R9 wrap irq");
        lane(0, 3'd0, "R9 flag sticky");
        lane(0, 3'd1, "R9 flag sticky");
        load(40'd5, "R8 clears flag");
        // R9 without interrupt enable
        set_cfg(mk_cfg(8'h80, 8'h00, 0, 0, 0, 0, 0, 0), "R9");
        load(TOP, "R9 preload");
        lane(0, 3'd1, "R9 wrap no irq_en");
        // R8 write collides with wrap
        set_cfg(mk_cfg(8'h80, 8'h00, 0, 0, 0, 0, 0, 1), "R9");
        load(TOP, "R9 preload");
        evt_cnt = '0; evt_cnt[2:0] = 3'd3;
        load(40'd9, "R8 write masks wrap");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            evt_cnt = 24'($urandom);
            priv    = 2'($urandom);
            halted  = ($urandom % 10) == 0;
            if ($urandom % 32 == 0) begin
                logic [7:0] code, um;
                code = ($urandom % 8 == 0) ? 8'($urandom) : (8'h80 | 8'($urandom % 8));
                um   = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
                cfg_wdata = {8'($urandom), um, code};
                cfg_wr = 1;
            end
            if ($urandom % 40 == 0) begin
                ctr_wdata = ($urandom % 2) ? (TOP - 40'($urandom % 16))
                                           : {8'($urandom), 32'($urandom)};
                ctr_wr = 1;
            end
            cycle(tag_of(m_cfg));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule